// File: doc/BRIEF.md
# LIN Header Recognition Filter

This block sits between a bit-level UART receiver and its receive FIFO. It watches the received byte stream and the receiver's break indication, and it recognises LIN frame headers. A header select picks how much of the header the block takes in hardware: the break alone, the break and sync byte, or the break, sync byte and protected identifier. Header bytes that the block takes are never passed on. The filter decides, byte by byte, whether the receiver's output goes to the FIFO.

In full-header mode the block compares the identifier with a programmed value. It opens the receive path only for frames addressed to this node, and it keeps the path open or shut until the next break. In every mode it reports that a header arrived, and it reports separately when the sync byte was wrong. Software clears both flags with a single clear pulse.

Top module: `lin_hdr_filter`

## Requirements
- R1: After reset, `hdr_flag` and `sync_err` are 0 and no header is in progress. With `hdr_mode` = 0, `rx_open` is 1 and incoming bytes are forwarded.
- R2: While `en` is 0, every byte strobe is forwarded, including one that arrives together with `rx_break`. Breaks are ignored, and the flags do not change.
- R3: Break-only mode (`hdr_mode` = 0). A break sets `hdr_flag` at the next clock edge, and the bytes that follow are forwarded.
- R4: Break-plus-sync mode (`hdr_mode` = 1). The first byte after a break is taken as sync and is never forwarded. It sets `hdr_flag`, and it also sets `sync_err` if it is not 0x55. Later bytes are forwarded.
- R5: Full-header mode (`hdr_mode` = 2 or 3). From a break until a matching identifier, `rx_open` is 0 and no byte is forwarded. Before the first break, all bytes are dropped.
- R6: Full-header mode. A break, then sync 0x55, then an identifier equal to `match_id` in all 8 bits sets `hdr_flag` only. The block then opens, and it forwards every following byte until the next break.
- R7: Full-header mode. A sync byte other than 0x55 sets `hdr_flag` and `sync_err` and shuts the receive path. Later bytes are dropped, including a correct sync or identifier, until the next break.
- R8: Full-header mode. A correct sync followed by an identifier that differs from `match_id` sets `hdr_flag` but not `sync_err`, and it shuts the receive path until the next break.
- R9: While `en` is 1, a break restarts header recognition from any state. A byte strobe in the same cycle as a break is dropped.
- R10: A `flag_clr` pulse clears `hdr_flag` and `sync_err` together. A flag that is being set in the same cycle stays set.
- R11: A forwarded byte keeps its value: `fwd_data` equals `rx_data` whenever `fwd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Header recognition enable; 0 gives transparent pass-through |
| hdr_mode | input | 2 | 0 break only, 1 break+sync, 2/3 break+sync+identifier |
| match_id | input | 8 | Identifier value to accept, parity bits included |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected (line low longer than one character time) |
| flag_clr | input | 1 | Clear pulse for both flags |
| fwd_valid | output | 1 | Byte is to be written into the receive FIFO |
| fwd_data | output | 8 | Byte for the receive FIFO |
| rx_open | output | 1 | Receive path currently passes bytes |
| hdr_flag | output | 1 | A header was received |
| sync_err | output | 1 | The sync byte of the last header was not 0x55 |

## Verification
The bench sweeps all 256 identifier values against a fixed match value. A filter that ignored the two parity bits would open on three wrong identifiers, and one that matched on the wrong byte would never open. It also sweeps all 256 sync values in break-plus-sync mode. An off-by-one byte position would leak the sync byte into the FIFO or drop the first payload byte. Further checks cover a good sync and identifier that arrive after a shut-down, which must stay dropped. They also cover a clear pulse that coincides with a new header, where losing the set would hide a frame, and a byte that arrives together with a break. Finally, the bench checks that a disabled filter forwards the bytes it would otherwise swallow.

// File: rtl/lin_hdr_filter.sv
module lin_hdr_filter #(
  parameter int W = 8,
  parameter logic [W-1:0] SYNC_VAL = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   hdr_mode,
  input  logic [W-1:0] match_id,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_break,
  input  logic         flag_clr,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data,
  output logic         rx_open,
  output logic         hdr_flag,
  output logic         sync_err
);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_ID, S_OPEN, S_SHUT} st_t;

  st_t  st, nxt;
  logic set_h, set_e;
  logic full;

  assign full      = hdr_mode[1];
  assign rx_open   = !en || st == S_OPEN || (st == S_IDLE && !full);
  assign fwd_valid = rx_valid && rx_open && !(en && rx_break);
  assign fwd_data  = rx_data;

  always_comb begin
    nxt   = st;
    set_h = 1'b0;
    set_e = 1'b0;
    if (!en) begin
      nxt = S_IDLE;
    end else if (rx_break) begin
      nxt   = (hdr_mode == 2'd0) ? S_OPEN : S_SYNC;
      set_h = (hdr_mode == 2'd0);
    end else if (rx_valid) begin
      case (st)
        S_SYNC: begin
          if (!full) begin
            set_h = 1'b1;
            set_e = rx_data != SYNC_VAL;
            nxt   = S_OPEN;
          end else if (rx_data == SYNC_VAL) begin
            nxt = S_ID;
          end else begin
            set_h = 1'b1;
            set_e = 1'b1;
            nxt   = S_SHUT;
          end
        end
        S_ID: begin
          set_h = 1'b1;
          nxt   = (rx_data == match_id) ? S_OPEN : S_SHUT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hdr_flag <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      st       <= nxt;
      hdr_flag <= set_h | (hdr_flag & !flag_clr);
      sync_err <= set_e | (sync_err & !flag_clr);
    end
  end

endmodule

module lin_hdr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] hdr_mode,
  input logic       rx_valid,
  input logic       rx_break,
  input logic       fwd_valid,
  input logic       rx_open,
  input logic       hdr_flag,
  input logic       sync_err
);

  p_disabled_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && rx_valid) |-> fwd_valid);

  p_break_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_break && hdr_mode == 2'd0) |=> hdr_flag);

  p_break_shuts_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_break && hdr_mode[1]) |=> !rx_open);

  p_fwd_when_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> rx_open);

  p_break_drops_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_break) |-> !fwd_valid);

  p_err_with_hdr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> hdr_flag);

endmodule

bind lin_hdr_filter lin_hdr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hdr_mode(hdr_mode),
  .rx_valid(rx_valid), .rx_break(rx_break), .fwd_valid(fwd_valid),
  .rx_open(rx_open), .hdr_flag(hdr_flag), .sync_err(sync_err)
);

// File: tb/tb_lin_hdr_filter.sv
module tb_lin_hdr_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MATCH = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] hdr_mode = 2'd0;
  logic [7:0] match_id = MATCH, rx_data = 8'h00;
  logic rx_valid = 1'b0, rx_break = 1'b0, flag_clr = 1'b0;
  logic fwd_valid, rx_open, hdr_flag, sync_err;
  logic [7:0] fwd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic got_fwd;
  logic [7:0] got_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_hdr_filter dut (
    .clk(clk), .rst_n(rst_n), .en(en), .hdr_mode(hdr_mode), .match_id(match_id),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break), .flag_clr(flag_clr),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .rx_open(rx_open),
    .hdr_flag(hdr_flag), .sync_err(sync_err)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic send(input logic [7:0] d, input logic brk, input logic clr);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_break = brk; flag_clr = clr;
    #1;
    got_fwd = fwd_valid; got_data = fwd_data;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 hdr_flag", hdr_flag, 0);
    chk("R1 sync_err", sync_err, 0);
    chk("R1 rx_open", rx_open, 1);
    send(8'h11, 0, 0);
    chk("R1 idle forward", got_fwd, 1);

    // R2 disabled: break ignored, bytes forwarded, flags unchanged
    en = 1'b0; hdr_mode = 2'd2;
    send(8'h22, 1, 0);
    chk("R2 fwd with break", got_fwd, 1);
    chk("R2 data", got_data, 8'h22);
    chk("R2 flag unchanged", hdr_flag, 0);
    send(8'h55, 0, 0);
    chk("R2 fwd sync-like byte", got_fwd, 1);
    chk("R2 still open", rx_open, 1);

    // R3 break-only mode
    en = 1'b1; hdr_mode = 2'd0;
    send(8'h00, 1, 0);
    chk("R3 flag after break", hdr_flag, 1);
    chk("R3 no err", sync_err, 0);
    send(8'h3C, 0, 0);
    chk("R3 forwarded", got_fwd, 1);
    chk("R11 data", got_data, 8'h3C);
    clear_flags();
    chk("R10 cleared", hdr_flag, 0);

    // R4 sweep of sync values in break+sync mode
    hdr_mode = 2'd1;
    for (int s = 0; s < 256; s++) begin
      send(8'h00, 1, 0);
      chk("R4 no flag on break", hdr_flag, 0);
      send(s[7:0], 0, 0);
      chk("R4 sync dropped", got_fwd, 0);
      chk("R4 flag", hdr_flag, 1);
      chk("R4 sync_err", sync_err, (s != 8'h55) ? 1 : 0);
      send(~s[7:0], 0, 0);
      chk("R4 payload fwd", got_fwd, 1);
      chk("R11 payload data", got_data, (~s) & 8'hFF);
      clear_flags();
      chk("R10 both cleared", hdr_flag + sync_err, 0);
    end

    // R5 full mode before any header: reset state to idle via disable
    en = 1'b0; @(negedge clk); en = 1'b1; hdr_mode = 2'd2;
    #1 chk("R5 closed before header", rx_open, 0);
    send(8'h77, 0, 0);
    chk("R5 dropped before header", got_fwd, 0);

    // R6/R8 sweep of identifier values
    for (int id = 0; id < 256; id++) begin
      send(8'h00, 1, 0);
      chk("R5 closed after break", rx_open, 0);
      send(8'h55, 0, 0);
      chk("R5 sync dropped", got_fwd, 0);
      send(id[7:0], 0, 0);
      chk("R5 id dropped", got_fwd, 0);
      chk("R6 flag", hdr_flag, 1);
      chk("R8 no sync_err", sync_err, 0);
      chk("R6 open iff match", rx_open, (id == MATCH) ? 1 : 0);
      send(8'h5A, 0, 0);
      chk("R6 payload fwd iff match", got_fwd, (id == MATCH) ? 1 : 0);
      clear_flags();
    end

    // R6 stays open over many bytes, R9 break restarts
    send(8'h00, 1, 0); send(8'h55, 0, 0); send(MATCH, 0, 0);
    for (int k = 0; k < 4; k++) begin
      send(8'h55 + k[7:0], 0, 0);
      chk("R6 stays open", got_fwd, 1);
    end
    send(8'h99, 1, 0);
    chk("R9 byte with break dropped", got_fwd, 0);
    chk("R9 closed after break", rx_open, 0);
    clear_flags();

    // R7 wrong sync shuts, later good header bytes still dropped
    send(8'h00, 1, 0);
    send(8'h54, 0, 0);
    chk("R7 flag", hdr_flag, 1);
    chk("R7 sync_err", sync_err, 1);
    chk("R7 shut", rx_open, 0);
    clear_flags();
    send(8'h55, 0, 0);
    send(MATCH, 0, 0);
    chk("R7 match ignored while shut", hdr_flag, 0);
    send(8'h10, 0, 0);
    chk("R7 payload dropped", got_fwd, 0);
    // R9 restart from shut state
    send(8'h00, 1, 0); send(8'h55, 0, 0); send(MATCH, 0, 0);
    chk("R9 reopened", rx_open, 1);

    // R10 clear in same cycle as set: set wins
    send(8'h00, 1, 0); send(8'h55, 0, 0);
    send(MATCH, 0, 1);
    chk("R10 set beats clear", hdr_flag, 1);
    send(8'h00, 1, 0);
    send(8'h13, 0, 1);
    chk("R10 set beats clear err", sync_err, 1);
    chk("R10 set beats clear hdr", hdr_flag, 1);
    clear_flags();
    chk("R10 err cleared", sync_err, 0);

    // R3 in break-only mode: break from shut state restarts and opens
    hdr_mode = 2'd0;
    send(8'h00, 1, 0);
    send(8'h42, 0, 0);
    chk("R3 open after break", got_fwd, 1);

    summary();
  end
endmodule